// File: doc/BRIEF.md
# Address-Selective TLB Flush Unit

This block is a small fully associative translation cache for the instruction-fetch side of a core. Each entry maps a virtual page number to a physical page number. A lookup returns the result in the same cycle. Refills write into a slot chosen by a round-robin pointer.

A fence instruction can invalidate entries in two ways. A fence with no address operand clears every entry in one cycle. A fence that carries an address removes only the entries whose tag matches that address. The targeted case uses the normal lookup comparator, so the timing-critical lookup address gets no extra multiplexer. On the fetch side the lookup address is the fetch PC. A small sequencer therefore steers the PC to the fence operand, and the next lookup performs the invalidation. The sequencer then steers the PC back to the instruction after the fence. While this runs, a busy flag tells the front end to accept no other redirect or fetch result.

Top module: `tlbSelFlush`

## Requirements
- R1: After reset every entry is invalid, and `seqBusy` and `redirValid` are 0. A lookup of any page, including page 0, misses.
- R2: When the sequencer is not in its flush-lookup state, `lkHit` is 1 in the same cycle as `lkValid` whenever a valid entry's tag equals `lkVpn`. `lkPpn` is then the data of the lowest-index matching entry.
- R3: A refill writes tag and data into the slot named by a round-robin pointer and marks that slot valid at the next edge. The pointer starts at slot 0 after reset and advances by one on every refill. It wraps after the last slot, so the oldest entry is overwritten.
- R4: A fence with `fenceHasAddr`=0, accepted while idle, invalidates every entry at the next edge. It produces no redirect and does not raise `seqBusy`.
- R5: A fence with `fenceHasAddr`=1, accepted while idle, drives `redirValid`=1 and `redirPc`=`fenceAddr` in the same cycle. `seqBusy` is 1 from the next cycle on.
- R6: In the flush-lookup state, `lkHit` is forced to 0. On the first cycle with `lkValid`=1, every valid entry whose tag equals `lkVpn` becomes invalid at the edge, and all other entries are kept.
- R7: The cycle after that flush lookup is the resume cycle. In it `redirValid`=1, `redirPc` equals the `fenceNextPc` captured when the fence was accepted, and `seqBusy` is still 1. The sequencer is idle in the following cycle.
- R8: A fence request presented while `seqBusy` is 1 is ignored. It clears no entry and starts no redirect.
- R9: When a refill and a flush happen in the same cycle, the flush wins for the refilled slot. The slot is left invalid under a flush-all, or under a targeted flush that matched that slot's previous tag. The pointer still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request (fetch PC presented) |
| lkVpn | input | VPN_W | Lookup virtual page number |
| lkHit | output | 1 | Lookup hit |
| lkPpn | output | PPN_W | Translated physical page number |
| fenceReq | input | 1 | Fence instruction request |
| fenceHasAddr | input | 1 | Fence carries an address operand |
| fenceAddr | input | VPN_W+PG_W | Fence address operand (virtual address) |
| fenceNextPc | input | VPN_W+PG_W | PC of the instruction after the fence |
| fillValid | input | 1 | Refill write strobe |
| fillVpn | input | VPN_W | Refill tag |
| fillPpn | input | PPN_W | Refill data |
| redirValid | output | 1 | Fetch PC redirect request |
| redirPc | output | VPN_W+PG_W | Redirect target PC |
| seqBusy | output | 1 | Flush sequence in progress |

## Verification
Lookup hit and data, and the first redirect to the fence operand, are combinational: they are due in the same cycle as the stimulus. Every invalidation and refill takes effect one edge later. `seqBusy` rises one edge after a targeted fence. The resume redirect comes one edge after the first valid lookup in the flush state. The bench drives inputs just after the falling edge and samples 2 ns later. A behavioural model updated on each rising edge predicts every output, so a result that comes one cycle early or late shows up as a mismatch on that cycle.

// File: rtl/tlbFlushPkg.sv
package tlbFlushPkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_LOOK   = 2'd1,
    SEQ_RESUME = 2'd2
  } seqState_t;

  // strobes from the control to the entry array
  typedef struct packed {
    logic flushAll;   // clear every valid bit
    logic flushSel;   // clear entries hit by the current lookup
    logic blockHit;   // lookup result must not be used
  } dpCtl_t;

endpackage

// File: rtl/tlbFlushDatapath.sv
module tlbFlushDatapath #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tlbFlushPkg::dpCtl_t  ctl,
  input  logic                 lkValid,
  input  logic [VPN_W-1:0]     lkVpn,
  output logic                 lkHit,
  output logic [PPN_W-1:0]     lkPpn,
  input  logic                 fillValid,
  input  logic [VPN_W-1:0]     fillVpn,
  input  logic [PPN_W-1:0]     fillPpn
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] entMatch;
  logic [VPN_W-1:0]   entVpn [ENTRIES];
  logic [PPN_W-1:0]   entPpn [ENTRIES];
  logic [PTR_W-1:0]   fillPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillPtr <= '0;
    end else if (fillValid) begin
      fillPtr <= (fillPtr == LAST) ? '0 : fillPtr + 1'b1;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic fillHere;
    logic killHere;

    // the one comparator per entry, shared by lookup and targeted flush
    assign entMatch[i] = entValid[i] && (entVpn[i] == lkVpn);
    assign fillHere    = fillValid && (fillPtr == PTR_W'(i));
    assign killHere    = ctl.flushAll || (ctl.flushSel && entMatch[i]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[i] <= 1'b0;
      end else if (killHere) begin
        entValid[i] <= 1'b0;
      end else if (fillHere) begin
        entValid[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fillHere) begin
        entVpn[i] <= fillVpn;
        entPpn[i] <= fillPpn;
      end
    end
  end

  always_comb begin
    lkPpn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (entMatch[i]) lkPpn = entPpn[i];
    end
  end

  assign lkHit = lkValid && (|entMatch) && !ctl.blockHit;

endmodule

// File: rtl/tlbFlushControl.sv
module tlbFlushControl #(
  parameter int VA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fenceReq,
  input  logic                 fenceHasAddr,
  input  logic [VA_W-1:0]      fenceAddr,
  input  logic [VA_W-1:0]      fenceNextPc,
  input  logic                 lkValid,
  output tlbFlushPkg::dpCtl_t  ctl,
  output logic                 redirValid,
  output logic [VA_W-1:0]      redirPc,
  output logic                 seqBusy
);
  import tlbFlushPkg::*;

  seqState_t       state, stateD;
  logic [VA_W-1:0] resumePc;
  logic            startSeq;

  assign startSeq = (state == SEQ_IDLE) && fenceReq && fenceHasAddr;

  always_comb begin
    stateD     = state;
    ctl        = '0;
    redirValid = 1'b0;
    redirPc    = fenceAddr;
    case (state)
      SEQ_IDLE: begin
        if (fenceReq) begin
          if (fenceHasAddr) begin
            redirValid = 1'b1;
            stateD     = SEQ_LOOK;
          end else begin
            ctl.flushAll = 1'b1;
          end
        end
      end
      SEQ_LOOK: begin
        ctl.blockHit = 1'b1;
        if (lkValid) begin
          ctl.flushSel = 1'b1;
          stateD       = SEQ_RESUME;
        end
      end
      SEQ_RESUME: begin
        redirValid = 1'b1;
        redirPc    = resumePc;
        stateD     = SEQ_IDLE;
      end
      default: stateD = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      resumePc <= '0;
    end else begin
      state <= stateD;
      if (startSeq) resumePc <= fenceNextPc;
    end
  end

  assign seqBusy = (state != SEQ_IDLE);

endmodule

// File: rtl/tlbSelFlush.sv
module tlbSelFlush #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PG_W    = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    lkValid,
  input  logic [VPN_W-1:0]        lkVpn,
  output logic                    lkHit,
  output logic [PPN_W-1:0]        lkPpn,
  input  logic                    fenceReq,
  input  logic                    fenceHasAddr,
  input  logic [VPN_W+PG_W-1:0]   fenceAddr,
  input  logic [VPN_W+PG_W-1:0]   fenceNextPc,
  input  logic                    fillValid,
  input  logic [VPN_W-1:0]        fillVpn,
  input  logic [PPN_W-1:0]        fillPpn,
  output logic                    redirValid,
  output logic [VPN_W+PG_W-1:0]   redirPc,
  output logic                    seqBusy
);
  localparam int VA_W = VPN_W + PG_W;

  tlbFlushPkg::dpCtl_t ctl;

  tlbFlushControl #(.VA_W(VA_W)) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .fenceReq     (fenceReq),
    .fenceHasAddr (fenceHasAddr),
    .fenceAddr    (fenceAddr),
    .fenceNextPc  (fenceNextPc),
    .lkValid      (lkValid),
    .ctl          (ctl),
    .redirValid   (redirValid),
    .redirPc      (redirPc),
    .seqBusy      (seqBusy)
  );

  tlbFlushDatapath #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .lkValid   (lkValid),
    .lkVpn     (lkVpn),
    .lkHit     (lkHit),
    .lkPpn     (lkPpn),
    .fillValid (fillValid),
    .fillVpn   (fillVpn),
    .fillPpn   (fillPpn)
  );

endmodule

// File: rtl/tlbFlushChk.sv
module tlbFlushChk (
  input logic clk,
  input logic rstN,
  input logic lkValid,
  input logic lkHit,
  input logic fenceReq,
  input logic fenceHasAddr,
  input logic fillValid,
  input logic redirValid,
  input logic seqBusy
);
  // R2
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> lkValid);

  // R4
  flush_all_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fenceReq && !fenceHasAddr && !seqBusy) |=> (!lkHit && !seqBusy));

  // R5
  seq_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fenceReq && fenceHasAddr && !seqBusy) |-> redirValid ##1 seqBusy);

  // R6
  look_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqBusy && !redirValid) |-> !lkHit);

  // R7
  resume_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqBusy && redirValid) |=> !seqBusy);

  // R8
  busy_no_early_redir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seqBusy && !redirValid && !lkValid) |=> (seqBusy && !redirValid));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!seqBusy && !redirValid && !(fillValid && 1'b0)));
endmodule

bind tlbSelFlush tlbFlushChk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .lkValid      (lkValid),
  .lkHit        (lkHit),
  .fenceReq     (fenceReq),
  .fenceHasAddr (fenceHasAddr),
  .fillValid    (fillValid),
  .redirValid   (redirValid),
  .seqBusy      (seqBusy)
);

// File: tb/sim_tlbSelFlush.sv
`timescale 1ns/1ps
module sim_tlbSelFlush;
  localparam int ENT   = 8;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int PG_W  = 12;
  localparam int VA_W  = VPN_W + PG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lkValid = 1'b0;
  logic [VPN_W-1:0] lkVpn = '0;
  logic lkHit;
  logic [PPN_W-1:0] lkPpn;
  logic fenceReq = 1'b0, fenceHasAddr = 1'b0;
  logic [VA_W-1:0] fenceAddr = '0, fenceNextPc = '0;
  logic fillValid = 1'b0;
  logic [VPN_W-1:0] fillVpn = '0;
  logic [PPN_W-1:0] fillPpn = '0;
  logic redirValid;
  logic [VA_W-1:0] redirPc;
  logic seqBusy;

  always #4 clk = ~clk;

  tlbSelFlush #(.ENTRIES(ENT), .VPN_W(VPN_W), .PPN_W(PPN_W), .PG_W(PG_W)) u0 (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn), .lkHit(lkHit),
    .lkPpn(lkPpn), .fenceReq(fenceReq), .fenceHasAddr(fenceHasAddr),
    .fenceAddr(fenceAddr), .fenceNextPc(fenceNextPc), .fillValid(fillValid),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .redirValid(redirValid),
    .redirPc(redirPc), .seqBusy(seqBusy));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural reference
  bit               mValid [ENT];
  logic [VPN_W-1:0] mVpn   [ENT];
  logic [PPN_W-1:0] mPpn   [ENT];
  int               mPtr;
  int               mState;   // 0 idle, 1 flush lookup, 2 resume
  logic [VA_W-1:0]  mNext;

  function automatic bit mMatch(int i);
    return mValid[i] && (mVpn[i] == lkVpn);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mValid[i]) mValid[i] = 0;
      mPtr = 0; mState = 0; mNext = '0;
    end else begin
      bit hitOld [ENT];
      bit fAll, fSel;
      foreach (hitOld[i]) hitOld[i] = mMatch(i);
      fAll = (mState == 0) && fenceReq && !fenceHasAddr;
      fSel = (mState == 1) && lkValid;
      if (fillValid) begin
        mValid[mPtr] = 1; mVpn[mPtr] = fillVpn; mPpn[mPtr] = fillPpn;
        mPtr = (mPtr + 1) % ENT;
      end
      for (int i = 0; i < ENT; i++) begin
        if (fAll || (fSel && hitOld[i])) mValid[i] = 0;
      end
      case (mState)
        0: if (fenceReq && fenceHasAddr) begin mState = 1; mNext = fenceNextPc; end
        1: if (lkValid) mState = 2;
        default: mState = 0;
      endcase
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      bit eHit, eRedir;
      logic [PPN_W-1:0] ePpn;
      logic [VA_W-1:0] ePc;
      eHit = 0; ePpn = '0;
      for (int i = ENT - 1; i >= 0; i--) if (mMatch(i)) begin eHit = 1; ePpn = mPpn[i]; end
      eHit  = eHit && lkValid && (mState != 1);
      eRedir = ((mState == 0) && fenceReq && fenceHasAddr) || (mState == 2);
      ePc   = (mState == 2) ? mNext : fenceAddr;
      chk("lkHit", 64'(lkHit), 64'(eHit));
      if (eHit) chk("lkPpn", 64'(lkPpn), 64'(ePpn));
      chk("redirValid", 64'(redirValid), 64'(eRedir));
      if (eRedir) chk("redirPc", 64'(redirPc), 64'(ePc));
      chk("seqBusy", 64'(seqBusy), 64'(mState != 0));
    end
  end

  task automatic clearIn();
    lkValid = 0; fenceReq = 0; fenceHasAddr = 0; fillValid = 0;
  endtask
  task automatic idle(); @(negedge clk); clearIn(); endtask
  task automatic fill(int v, int p);
    @(negedge clk); clearIn();
    fillValid = 1; fillVpn = VPN_W'(v); fillPpn = PPN_W'(p);
  endtask
  task automatic look(int v);
    @(negedge clk); clearIn(); lkValid = 1; lkVpn = VPN_W'(v);
  endtask
  task automatic fence(bit has, int addr, int nxt);
    @(negedge clk); clearIn();
    fenceReq = 1; fenceHasAddr = has;
    fenceAddr = VA_W'(addr); fenceNextPc = VA_W'(nxt);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1: empty after reset, page 0 must miss
    phase = "R1";
    look(0); look(5); idle();
    // R2 / R3: fill and look up
    phase = "R2";
    fill('h10, 'hA10); fill('h11, 'hA11); fill('h12, 'hA12);
    look('h10); look('h12); look('h11); look('h13); idle();
    // R3: wrap of the round-robin pointer
    phase = "R3";
    for (int k = 0; k < 10; k++) fill('h100 + k, 'h900 + k);
    for (int k = 0; k < 10; k++) look('h100 + k);
    look('h10); idle();
    // R4: flush without address
    phase = "R4";
    fence(0, 0, 0);
    for (int k = 2; k < 10; k++) look('h100 + k);
    // R5 / R6 / R7: targeted flush through the fetch PC
    phase = "R5";
    for (int k = 0; k < 8; k++) fill('h200 + k, 'hB00 + k);
    fence(1, ('h203 << PG_W) | 'h44, 'h7777_0004);
    phase = "R8";
    idle();
    @(negedge clk); clearIn(); fenceReq = 1; fenceHasAddr = 0;  // ignored while busy
    @(negedge clk); clearIn(); fenceReq = 1; fenceHasAddr = 1; fenceAddr = 'h5000;
    phase = "R6";
    look('h203);
    phase = "R7";
    look('h205);
    phase = "R6";
    for (int k = 0; k < 8; k++) look('h200 + k);
    idle();
    // R9: refill together with flushes
    phase = "R9";
    fence(0, 0, 0); fillValid = 1; fillVpn = 'h300; fillPpn = 'hC00;
    look('h300);
    for (int k = 0; k < 8; k++) fill('h310 + k, 'hC10 + k);
    fence(1, 'h310 << PG_W, 'h1234_5678);
    @(negedge clk); clearIn();
    lkValid = 1; lkVpn = 'h310; fillValid = 1; fillVpn = 'h3AA; fillPpn = 'hCAA;
    idle();
    look('h3AA); look('h310); look('h311);
    fill('h3BB, 'hCBB); look('h3BB); look('h312);
    idle(); idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule